// File: doc/BRIEF.md
# Pulse Accumulator with Gated Timing

An 8-bit pulse accumulator for a timer subsystem. The asynchronous input pin is first brought into the clock domain by a two-flop synchronizer. In event mode the counter advances once for each qualified edge of the synchronized pin. In gated timing mode it advances once for every 64 system clocks, but only while the synchronized pin is at its active level. A single polarity control bit serves both modes. In event mode it chooses which edge is counted. In gated mode it chooses which pin level holds the count still.

Software may load any value into the counter at any time. A load takes effect on the next clock edge and wins over an increment in the same cycle. Each increment that takes the counter from its all-ones value back to zero sets a sticky overflow flag. Software clears the flag by writing a one to it. A remainder count can therefore be preloaded: after loading the two's complement of N, the first overflow comes after N more counted events. The divide-by-64 prescaler runs all the time. Opening the gate does not restart it, so short gate intervals still add up to elapsed time.

Top module: `pacc_top`

## Requirements
- R1: While reset is held, and after it is released, cnt_rdata reads 0 and ovf_flag reads 0 until something is counted or written.
- R2: With en=1, mode=0 (event) and edge_sel=0, the counter advances by exactly 1 for each rising edge of pai_async. Falling edges leave it unchanged.
- R3: With en=1, mode=0 and edge_sel=1, the counter advances by exactly 1 for each falling edge of pai_async. Rising edges leave it unchanged.
- R4: An increment from 8'hFF to 8'h00 sets ovf_flag. Starting from 0, the flag first becomes 1 on the 256th counted event and sets again on the 512th.
- R5: A write with cnt_wr=1 loads cnt_wdata into the counter on the next clock edge. After loading 8'hFD, two events give 8'hFF with no overflow, and the third gives 8'h00 with ovf_flag=1.
- R6: With en=1, mode=1 (gated) and edge_sel=0, the counter advances exactly once per 64 clock cycles while the pin is high. It holds while the pin is low. Two gated increments are never less than 64 cycles apart.
- R7: With en=1, mode=1 and edge_sel=1, the pin level is inverted for the gate. A high pin inhibits counting, and a low pin lets the counter advance once per 64 clock cycles.
- R8: The prescaler is free-running and is not restarted when the gate opens. A gate that is open for 32 cycles and closed for 64, repeated, yields exactly one increment per 192 cycles.
- R9: A counter write in the same cycle as an increment loads cnt_wdata, and the increment is lost. A write never sets ovf_flag, even a write of 8'h00 while the counter holds 8'hFF.
- R10: ovf_flag stays 1 until a cycle with flag_wr=1 and flag_wdata=1 clears it. flag_wr=1 with flag_wdata=0 has no effect. An overflow in the same cycle as a clear leaves the flag at 1.
- R11: With en=0 the counter holds its value in both modes, and software writes still load it.
- R12: A change on pai_async reaches the counter through two synchronizer flops and an edge register. For a rising edge applied between clock edges in event mode, the count is unchanged after the second clock edge and incremented after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pai_async | input | 1 | Asynchronous accumulator input pin |
| en | input | 1 | Accumulator enable; counting stops when low |
| mode | input | 1 | 0 = event counting, 1 = gated timing |
| edge_sel | input | 1 | 0 = rising edge / gate open when high; 1 = falling edge / gate open when low |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Value loaded on a counter write |
| cnt_rdata | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write data; a one clears the flag |

## Verification
The bench aims at the wrap boundary and its timing. It preloads 8'hFD and counts 255 and 256 events from zero. A counter that flags one event early or late, or that flags on a software load, fails there. It lines a flag clear up with a wrap in the same cycle, and it holds a counter write through several prescaler ticks. If clear won over set, or an increment won over a write, the flag would be lost or the count would leak past the written value. In gated mode it measures whole 64-cycle windows and drives a 32-open/64-closed gate pattern. A prescaler that restarts when the gate opens would count nothing under that pattern. A synchronizer of the wrong depth moves the first increment off the third clock edge.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  typedef enum logic {
    PACC_EVENT = 1'b0,
    PACC_GATED = 1'b1
  } pacc_mode_e;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } pacc_pin_s;

endpackage

// File: rtl/pacc_rst_sync.sv
module pacc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pacc_pin_sync.sv
module pacc_pin_sync
  import pacc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_async,
  output pacc_pin_s pin
);

  logic [STAGES-1:0] stage_q;
  logic              prev_q;
  logic              level;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic stage_d;
    if (g == 0) begin : g_first
      assign stage_d = pin_async;
    end else begin : g_rest
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= 1'b0;
      end else begin
        stage_q[g] <= stage_d;
      end
    end
  end

  assign level = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= level;
    end
  end

  always_comb begin
    pin.level = level;
    pin.rise  = level & ~prev_q;
    pin.fall  = ~level & prev_q;
  end

endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
  parameter int PRE_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] div_d;

  always_comb begin
    div_d = div_q + 1'b1;
    tick  = &div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             flag_q;
  logic             flag_d;
  logic             wrap;
  logic             cnt_en;

  always_comb begin
    wrap   = inc & ~wr & (&cnt_q);
    cnt_en = inc | wr;
    if (wr) begin
      cnt_d = wdata;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    flag_d = wrap | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

endmodule

// File: rtl/pacc_top.sv
module pacc_top
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pai_async,
  input  logic             en,
  input  logic             mode,
  input  logic             edge_sel,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  output logic             ovf_flag,
  input  logic             flag_wr,
  input  logic             flag_wdata
);

  logic       rst_int_n;
  pacc_pin_s  pin;
  logic       tick;
  logic       edge_hit;
  logic       gate_open;
  logic       inc;
  logic       flag_clr;
  pacc_mode_e mode_e;

  pacc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pacc_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin_async (pai_async),
    .pin       (pin)
  );

  pacc_prescale #(.PRE_W(PRE_W)) u_prescale (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick)
  );

  always_comb begin
    mode_e    = pacc_mode_e'(mode);
    edge_hit  = edge_sel ? pin.fall : pin.rise;
    gate_open = edge_sel ? ~pin.level : pin.level;
    unique case (mode_e)
      PACC_GATED: inc = en & tick & gate_open;
      default:    inc = en & edge_hit;
    endcase
    flag_clr = flag_wr & flag_wdata;
  end

  pacc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .inc      (inc),
    .wr       (cnt_wr),
    .wdata    (cnt_wdata),
    .flag_clr (flag_clr),
    .cnt      (cnt_rdata),
    .flag     (ovf_flag)
  );

endmodule

// File: rtl/pacc_checker.sv
module pacc_checker #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             mode,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_rdata,
  input logic             ovf_flag,
  input logic             flag_wr,
  input logic             flag_wdata
);

  localparam int GAP_W = PRE_W + 1;
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'((1 << PRE_W) - 1);

  logic [CNT_W-1:0] rdata_q;
  logic [CNT_W-1:0] rdata_inc;
  logic             wr_q;
  logic             mode_q;
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  logic             changed;
  logic             gated_step;

  always_comb begin
    rdata_inc  = rdata_q + 1'b1;
    changed    = (cnt_rdata != rdata_q);
    gated_step = mode & mode_q & ~wr_q & changed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      wr_q    <= 1'b0;
      mode_q  <= 1'b0;
      gap_q   <= '0;
      seen_q  <= 1'b0;
    end else begin
      rdata_q <= cnt_rdata;
      wr_q    <= cnt_wr;
      mode_q  <= mode;
      if (changed) begin
        gap_q <= '0;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
      if (cnt_wr || !mode) begin
        seen_q <= 1'b0;
      end else if (gated_step) begin
        seen_q <= 1'b1;
      end
    end
  end

  // R5: a write is loaded on the next edge
  p_write_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_rdata == $past(cnt_wdata)));

  // R2: without a write the counter only holds or steps by one
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_q |-> (cnt_rdata == rdata_q || cnt_rdata == rdata_inc));

  // R4: an increment across all-ones sets the flag
  p_wrap_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_q && (&rdata_q) && cnt_rdata == '0) |-> ovf_flag);

  // R9: the flag rises only on a counted wrap, never on a write
  p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (!wr_q && (&rdata_q) && cnt_rdata == '0));

  // R10: the flag stays set unless a one is written to it
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(flag_wr && flag_wdata)) |=> ovf_flag);

  // R11: disabled and not written means the count holds
  p_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(cnt_rdata));

  // R6: gated increments are spaced by at least the prescaler period
  p_gated_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_step && seen_q) |-> (gap_q >= GAP_MIN));

endmodule

bind pacc_top pacc_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_pacc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .mode       (mode),
  .cnt_wr     (cnt_wr),
  .cnt_wdata  (cnt_wdata),
  .cnt_rdata  (cnt_rdata),
  .ovf_flag   (ovf_flag),
  .flag_wr    (flag_wr),
  .flag_wdata (flag_wdata)
);

// File: tb/pacc_top_bench.sv
`timescale 1ns/1ps
module pacc_top_bench;

  logic       clk;
  logic       rst_n;
  logic       pai_async;
  logic       en;
  logic       mode;
  logic       edge_sel;
  logic       cnt_wr;
  logic [7:0] cnt_wdata;
  logic [7:0] cnt_rdata;
  logic       ovf_flag;
  logic       flag_wr;
  logic       flag_wdata;

  int  total;
  int  bad;
  bit  done;
  int  seed_val;

  pacc_top u_pacc_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .pai_async  (pai_async),
    .en         (en),
    .mode       (mode),
    .edge_sel   (edge_sel),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (cnt_wdata),
    .cnt_rdata  (cnt_rdata),
    .ovf_flag   (ovf_flag),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] f_cnt(input logic [7:0] start, input int n);
    return 8'((int'(start) + n) % 256);
  endfunction

  function automatic logic f_wrap(input logic [7:0] start, input int n);
    return (int'(start) + n) >= 256;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    @(negedge clk);
    cnt_wr    = 1'b1;
    cnt_wdata = v;
    @(negedge clk);
    cnt_wr    = 1'b0;
  endtask

  task automatic wr_flag(input logic v);
    @(negedge clk);
    flag_wr    = 1'b1;
    flag_wdata = v;
    @(negedge clk);
    flag_wr    = 1'b0;
  endtask

  // active level is the level that is entered on the counted edge
  task automatic pulses(input int n, input logic falling);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pai_async = ~falling;
      cycles(3);
      pai_async = falling;
      cycles(3);
    end
    cycles(4);
  endtask

  initial begin
    seed_val = $urandom(32'h5eed);
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; pai_async = 1'b0; en = 1'b0; mode = 1'b0; edge_sel = 1'b0;
    cnt_wr = 1'b0; cnt_wdata = '0; flag_wr = 1'b0; flag_wdata = 1'b0;
    cycles(3);
    chk("R1 count in reset", cnt_rdata, 0);
    chk("R1 flag in reset", ovf_flag, 0);
    rst_n = 1'b1;
    cycles(4);
    chk("R1 count after reset", cnt_rdata, 0);
    chk("R1 flag after reset", ovf_flag, 0);

    // R12: synchronizer latency
    en = 1'b1;
    @(negedge clk);
    pai_async = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 chk("R12 no count after second edge", cnt_rdata, 0);
    @(posedge clk);
    #1 chk("R12 count after third edge", cnt_rdata, 1);
    @(negedge clk);
    pai_async = 1'b0;
    cycles(6);
    chk("R2 falling edge ignored", cnt_rdata, 1);

    // R2: random rising-edge bursts
    for (int it = 0; it < 6; it++) begin
      logic [7:0] st;
      int n;
      st = cnt_rdata;
      n  = $urandom_range(1, 20);
      pulses(n, 1'b0);
      chk("R2 rising edge count", cnt_rdata, f_cnt(st, n));
    end

    // R3: falling edges
    wr_cnt(8'h00);
    edge_sel = 1'b1;
    @(negedge clk);
    pai_async = 1'b1;
    cycles(6);
    chk("R3 rising edge ignored", cnt_rdata, 0);
    for (int it = 0; it < 4; it++) begin
      logic [7:0] st;
      int n;
      st = cnt_rdata;
      n  = $urandom_range(1, 15);
      pulses(n, 1'b1);
      chk("R3 falling edge count", cnt_rdata, f_cnt(st, n));
    end

    // R4: 256th and 512th events
    edge_sel = 1'b1;
    @(negedge clk);
    pai_async = 1'b0;
    cycles(4);
    edge_sel = 1'b0;
    cycles(2);
    wr_cnt(8'h00);
    wr_flag(1'b1);
    pulses(255, 1'b0);
    chk("R4 count after 255", cnt_rdata, 8'hFF);
    chk("R4 no flag after 255", ovf_flag, 0);
    pulses(1, 1'b0);
    chk("R4 count after 256", cnt_rdata, 8'h00);
    chk("R4 flag after 256", ovf_flag, 1);
    wr_flag(1'b0);
    chk("R10 zero write keeps flag", ovf_flag, 1);
    wr_flag(1'b1);
    chk("R10 one write clears flag", ovf_flag, 0);
    pulses(255, 1'b0);
    chk("R4 no flag after 511", ovf_flag, 0);
    pulses(1, 1'b0);
    chk("R4 flag after 512", ovf_flag, 1);

    // R5: remainder preload
    wr_flag(1'b1);
    wr_cnt(8'hFD);
    chk("R5 loaded value", cnt_rdata, 8'hFD);
    pulses(2, 1'b0);
    chk("R5 count after two", cnt_rdata, 8'hFF);
    chk("R5 no flag after two", ovf_flag, 0);
    pulses(1, 1'b0);
    chk("R5 count after three", cnt_rdata, 8'h00);
    chk("R5 flag after three", ovf_flag, 1);

    // R10: overflow and clear in the same cycle
    wr_cnt(8'hFF);
    @(negedge clk);
    pai_async = 1'b1;
    @(negedge clk);
    @(negedge clk);
    flag_wr = 1'b1; flag_wdata = 1'b1;
    @(negedge clk);
    flag_wr = 1'b0; flag_wdata = 1'b0;
    chk("R10 set wins over clear", ovf_flag, 1);
    chk("R10 wrapped count", cnt_rdata, 8'h00);
    @(negedge clk);
    pai_async = 1'b0;
    cycles(5);
    wr_flag(1'b1);

    // R11: disabled, event then gated
    en = 1'b0;
    wr_cnt(8'h42);
    chk("R11 write while disabled", cnt_rdata, 8'h42);
    pulses(5, 1'b0);
    chk("R11 event hold", cnt_rdata, 8'h42);
    mode = 1'b1;
    @(negedge clk);
    pai_async = 1'b1;
    cycles(300);
    chk("R11 gated hold", cnt_rdata, 8'h42);

    // R6: gated, active high
    en = 1'b1;
    for (int it = 0; it < 3; it++) begin
      logic [7:0] st;
      int k;
      cycles(4);
      st = cnt_rdata;
      k  = $urandom_range(1, 6);
      cycles(64 * k);
      chk("R6 gated windows", cnt_rdata, f_cnt(st, k));
    end
    @(negedge clk);
    pai_async = 1'b0;
    cycles(4);
    begin
      logic [7:0] st;
      st = cnt_rdata;
      cycles(300);
      chk("R6 low pin inhibits", cnt_rdata, st);
    end

    // R7: gated, active low
    edge_sel = 1'b1;
    for (int it = 0; it < 2; it++) begin
      logic [7:0] st;
      int k;
      cycles(4);
      st = cnt_rdata;
      k  = $urandom_range(1, 5);
      cycles(64 * k);
      chk("R7 low pin counts", cnt_rdata, f_cnt(st, k));
    end
    @(negedge clk);
    pai_async = 1'b1;
    cycles(4);
    begin
      logic [7:0] st;
      st = cnt_rdata;
      cycles(300);
      chk("R7 high pin inhibits", cnt_rdata, st);
    end

    // R8: short gate intervals accumulate
    edge_sel = 1'b0;
    @(negedge clk);
    pai_async = 1'b0;
    cycles(4);
    begin
      logic [7:0] st;
      st = cnt_rdata;
      for (int p = 0; p < 8; p++) begin
        pai_async = 1'b1;
        cycles(32);
        pai_async = 1'b0;
        cycles(64);
      end
      cycles(4);
      chk("R8 free prescaler", cnt_rdata, f_cnt(st, 4));
    end

    // R9: write holds against increments
    @(negedge clk);
    pai_async = 1'b1;
    cycles(4);
    wr_flag(1'b1);
    begin
      int miss;
      miss = 0;
      @(negedge clk);
      cnt_wr = 1'b1; cnt_wdata = 8'hFF;
      for (int c = 0; c < 200; c++) begin
        @(negedge clk);
        if (cnt_rdata !== 8'hFF) miss++;
      end
      cnt_wr = 1'b0;
      chk("R9 write wins over increment", miss, 0);
      chk("R9 no flag from write", ovf_flag, 0);
    end
    @(negedge clk);
    pai_async = 1'b0;
    cycles(4);
    wr_cnt(8'h00);
    chk("R9 write of zero from FF", ovf_flag, 0);

    // mixed random preload and event runs
    mode = 1'b0;
    cycles(4);
    for (int it = 0; it < 8; it++) begin
      logic [7:0] v;
      int n;
      v = 8'($urandom_range(0, 255));
      n = $urandom_range(1, 40);
      wr_flag(1'b1);
      wr_cnt(v);
      pulses(n, 1'b0);
      chk("R5 random preload count", cnt_rdata, f_cnt(v, n));
      chk("R4 random preload flag", ovf_flag, f_wrap(v, n));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule